// File: doc/BRIEF.md
# Packet Receive FIFO Read Port

This block is the device-side source of a 32-bit packet receive interface. Packet words arrive on a write interface that selects one of several port queues. The block drains those queues toward a system-side reader, one word per read step, and all of it runs on one clock. Each output word carries 32 data bits, a valid flag, start-of-packet and end-of-packet markers, a 2-bit count of unused bytes for the final word, and an odd parity bit.

The reader controls the pace with an active-low read enable. When the enable is sampled low, the block takes one step and the outputs change on the next rising edge. When the enable is sampled high, every output holds its value. At each packet boundary, the block picks the next non-empty port in round-robin order. It then places that port's number on the data bus in an address word, marked by an address flag and sent with valid low, and only after that does it send the packet body.

Top module: `prx_read_port`

## Requirements
- R1: After synchronous reset, out_val, out_adr, out_sop and out_eop are 0, out_dat and out_mod are 0, and out_prty is 1.
- R2: When rd_enb_n is sampled low at a rising edge, the block takes exactly one step, and the outputs show its result after that edge. Across steps, every queued word is delivered exactly once, in write order.
- R3: When rd_enb_n is sampled high, every output keeps its previous value after the edge, even in the middle of a packet.
- R4: out_prty makes the total number of ones in {out_dat, out_prty} odd on every cycle, address words included.
- R5: The step after a word with out_val=1 and out_eop=1 always produces out_val=0.
- R6: If the queue of the port being read is empty in the middle of a packet, the step produces out_val=0. The next available word then follows with out_sop=0.
- R7: An address word has out_adr=1 and out_val=0. It carries the port number in out_dat[1:0] and zeros above that. The step after it produces that port's first word with out_val=1 and out_sop=1.
- R8: A new port is chosen only at a packet boundary. The search starts at the port after the one served last (port 0 after reset), wraps around, and skips empty queues. A step with no non-empty queue produces out_val=0 and out_adr=0.
- R9: On the end-of-packet word, out_mod gives the number of unused trailing bytes (0 means all four bytes are used). On other valid words, out_mod is 0.
- R10: Byte order is big-endian. The first octet of a word sits in bits 31:24 on both wr_data and out_dat, and the data passes through unchanged.
- R11: wr_full[p] is 1 when port p holds DEPTH words. A write to a full port is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one word into the selected port queue |
| wr_port | input | 2 | Port queue to write |
| wr_data | input | 32 | Packet word, first octet in bits 31:24 |
| wr_eop | input | 1 | Word ends its packet |
| wr_mod | input | 2 | Unused trailing bytes of an end word |
| wr_full | output | 4 | Per-port queue full |
| rd_enb_n | input | 1 | Active-low read step request |
| out_dat | output | 32 | Packet data or port address |
| out_mod | output | 2 | Unused trailing bytes on the end word |
| out_prty | output | 1 | Odd parity over out_dat |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| out_val | output | 1 | Packet word is valid |
| out_adr | output | 1 | Word carries a port address |

## Verification
Some rules are checked by the assertions on every cycle:
- outputs hold while the enable is high,
- odd parity,
- valid drops after an end word,
- an address word is followed by a start word,
- out_mod is zero on words that are not the last,
- no queue is read while it is empty,
- a full queue does not change on a write.

Other behaviour shows only through the bench's scenarios:
- round-robin order across ports and the skipping of empty queues,
- exact delivery of the data and of the port numbers,
- resuming after a queue runs dry mid-packet,
- the dropping of a write beyond the queue depth.

// File: rtl/prx_pkg.sv
package prx_pkg;

    localparam int DATA_W = 32;
    localparam int MOD_W  = 2;

    typedef struct packed {
        logic              eop;
        logic [MOD_W-1:0]  mod;
        logic [DATA_W-1:0] dat;
    } prx_entry_t;

    typedef struct packed {
        logic              val;
        logic              adr;
        logic              sop;
        logic              eop;
        logic              prty;
        logic [MOD_W-1:0]  mod;
        logic [DATA_W-1:0] dat;
    } prx_word_t;

    typedef enum logic {
        ST_PICK = 1'b0,
        ST_BODY = 1'b1
    } prx_state_t;

    // odd parity bit for a data word
    function automatic logic odd_par(input logic [DATA_W-1:0] d);
        return ~(^d);
    endfunction

    function automatic prx_word_t idle_word();
        prx_word_t w;
        w      = '0;
        w.prty = odd_par('0);
        return w;
    endfunction

endpackage

// File: rtl/prx_fifo.sv
module prx_fifo
    import prx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  prx_entry_t din,
    output logic       full,
    input  logic       rd,
    output prx_entry_t dout,
    output logic       empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    prx_entry_t mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          wr_ok, rd_ok;

    assign full  = (cnt == (AW+1)'(DEPTH));
    assign empty = (cnt == '0);
    assign wr_ok = wr && !full;
    assign rd_ok = rd && !empty;
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (rd_ok) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // the controller never pops a queue that is empty
    p_no_pop_empty_r2: assert property (@(posedge clk) disable iff (rst)
        rd |-> !empty);

    // a write to a full queue with no pop leaves the fill level unchanged
    p_full_drop_r11: assert property (@(posedge clk) disable iff (rst)
        (wr && full && !rd) |=> $stable(cnt));

endmodule

// File: rtl/prx_rr_pick.sv
module prx_rr_pick #(
    parameter int N    = 4,
    parameter int PA_W = 2
) (
    input  logic [N-1:0]    req,
    input  logic [PA_W-1:0] last,
    output logic            found,
    output logic [PA_W-1:0] pick
);
    int unsigned idx;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        idx   = 0;
        for (int i = 1; i <= N; i++) begin
            idx = (int'(last) + i) % N;
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = PA_W'(idx);
            end
        end
    end

endmodule

// File: rtl/prx_out_reg.sv
module prx_out_reg
    import prx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step,
    input  prx_word_t nxt,
    output prx_word_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= idle_word();
        else if (step) q <= nxt;
    end

    // no step requested: output word holds
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(q));

endmodule

// File: rtl/prx_read_port.sv
module prx_read_port
    import prx_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [$clog2(NPORTS)-1:0]  wr_port,
    input  logic [31:0]                wr_data,
    input  logic                       wr_eop,
    input  logic [1:0]                 wr_mod,
    output logic [NPORTS-1:0]          wr_full,
    input  logic                       rd_enb_n,
    output logic [31:0]                out_dat,
    output logic [1:0]                 out_mod,
    output logic                       out_prty,
    output logic                       out_sop,
    output logic                       out_eop,
    output logic                       out_val,
    output logic                       out_adr
);
    localparam int PA_W = $clog2(NPORTS);

    prx_entry_t  heads [NPORTS];
    logic [NPORTS-1:0] q_empty, pop;
    prx_entry_t  wr_ent;

    prx_state_t  st, st_n;
    logic [PA_W-1:0] cur, cur_n, last, last_n;
    logic        first, first_n;
    logic        found;
    logic [PA_W-1:0] pick;
    logic        step;
    prx_word_t   nxt, q;
    prx_entry_t  hd;

    assign step   = !rd_enb_n;
    assign wr_ent = '{eop: wr_eop, mod: wr_mod, dat: wr_data};

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        prx_fifo #(.DEPTH(DEPTH)) i_fifo (
            .clk   (clk),
            .rst   (rst),
            .wr    (wr_en && (wr_port == PA_W'(p))),
            .din   (wr_ent),
            .full  (wr_full[p]),
            .rd    (pop[p]),
            .dout  (heads[p]),
            .empty (q_empty[p])
        );
    end

    prx_rr_pick #(.N(NPORTS), .PA_W(PA_W)) i_pick (
        .req   (~q_empty),
        .last  (last),
        .found (found),
        .pick  (pick)
    );

    assign hd = heads[cur];

    always_comb begin
        nxt     = idle_word();
        pop     = '0;
        st_n    = st;
        cur_n   = cur;
        last_n  = last;
        first_n = first;
        case (st)
            ST_PICK: begin
                if (found) begin
                    nxt.adr = 1'b1;
                    nxt.dat = 32'(pick);
                    st_n    = ST_BODY;
                    cur_n   = pick;
                    first_n = 1'b1;
                end
            end
            default: begin
                if (!q_empty[cur]) begin
                    pop[cur] = step;
                    nxt.val  = 1'b1;
                    nxt.sop  = first;
                    nxt.eop  = hd.eop;
                    nxt.mod  = hd.eop ? hd.mod : '0;
                    nxt.dat  = hd.dat;
                    first_n  = 1'b0;
                    if (hd.eop) begin
                        st_n   = ST_PICK;
                        last_n = cur;
                    end
                end
            end
        endcase
        nxt.prty = odd_par(nxt.dat);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_PICK;
            cur   <= '0;
            last  <= PA_W'(NPORTS-1);
            first <= 1'b0;
        end else if (step) begin
            st    <= st_n;
            cur   <= cur_n;
            last  <= last_n;
            first <= first_n;
        end
    end

    prx_out_reg i_out (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .nxt  (nxt),
        .q    (q)
    );

    assign out_dat  = q.dat;
    assign out_mod  = q.mod;
    assign out_prty = q.prty;
    assign out_sop  = q.sop;
    assign out_eop  = q.eop;
    assign out_val  = q.val;
    assign out_adr  = q.adr;

    p_odd_parity_r4: assert property (@(posedge clk) disable iff (rst)
        ($countones({out_dat, out_prty}) % 2) == 1);

    p_val_drop_eop_r5: assert property (@(posedge clk) disable iff (rst)
        (step && out_val && out_eop) |=> !out_val);

    p_adr_then_sop_r7: assert property (@(posedge clk) disable iff (rst)
        (step && out_adr) |=> (out_val && out_sop && !out_adr));

    p_mod_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (out_val && !out_eop) |-> (out_mod == '0));

endmodule

// File: tb/test_prx_read_port.sv
module test_prx_read_port;
    localparam int NP = 4;
    localparam int DP = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_port = '0;
    logic [31:0] wr_data = '0;
    logic        wr_eop = 1'b0;
    logic [1:0]  wr_mod = '0;
    logic [NP-1:0] wr_full;
    logic        rd_enb_n = 1'b1;
    logic [31:0] out_dat;
    logic [1:0]  out_mod;
    logic        out_prty, out_sop, out_eop, out_val, out_adr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    prx_read_port #(.NPORTS(NP), .DEPTH(DP)) i_prx_read_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port(wr_port),
        .wr_data(wr_data), .wr_eop(wr_eop), .wr_mod(wr_mod), .wr_full(wr_full),
        .rd_enb_n(rd_enb_n), .out_dat(out_dat), .out_mod(out_mod),
        .out_prty(out_prty), .out_sop(out_sop), .out_eop(out_eop),
        .out_val(out_val), .out_adr(out_adr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // compare all outputs; dat/mod/sop/eop compared for valid or address words
    task automatic chk_word(input string req, input bit v, input bit a, input bit s,
                            input bit e, input logic [1:0] m, input logic [31:0] d);
        check(out_val == v, req, "val", 64'(out_val), 64'(v));
        check(out_adr == a, req, "adr", 64'(out_adr), 64'(a));
        check(($countones({out_dat, out_prty}) % 2) == 1, req, "parity",
              64'(out_prty), 64'(~^out_dat));
        if (v || a) begin
            check(out_dat == d, req, "dat", 64'(out_dat), 64'(d));
            check(out_sop == s, req, "sop", 64'(out_sop), 64'(s));
            check(out_eop == e, req, "eop", 64'(out_eop), 64'(e));
            check(out_mod == m, req, "mod", 64'(out_mod), 64'(m));
        end
    endtask

    task automatic put(input logic [1:0] p, input logic [31:0] d,
                       input bit e, input logic [1:0] m);
        wr_en = 1'b1; wr_port = p; wr_data = d; wr_eop = e; wr_mod = m;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic step();
        rd_enb_n = 1'b0;
        @(posedge clk); #1;
        rd_enb_n = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk_word("R1", 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0);
        check(out_dat == 0 && out_prty == 1'b1 && !out_sop && !out_eop && out_mod == 0,
              "R1", "reset word", {31'd0, out_prty, out_dat}, 64'h1_0000_0000);
        rst = 1'b0;
        @(posedge clk); #1;
        step();
        chk_word("R8", 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0);
    endtask

    // port 0, three words, last one with two unused bytes
    task automatic t_basic();
        put(2'd0, 32'hA1B2_C3D4, 1'b0, 2'd0);
        put(2'd0, 32'h0102_0304, 1'b0, 2'd0);
        put(2'd0, 32'hEE77_0000, 1'b1, 2'd2);
        step(); chk_word("R7", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'd0);
        step(); chk_word("R10", 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 32'hA1B2_C3D4);
        check(out_dat[31:24] == 8'hA1, "R10", "first octet", 64'(out_dat[31:24]), 64'hA1);
        step(); chk_word("R2", 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0102_0304);
        step(); chk_word("R9", 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 32'hEE77_0000);
        step(); chk_word("R5", 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0);
    endtask

    // reader pauses mid-packet on port 1
    task automatic t_hold();
        put(2'd1, 32'h1111_2222, 1'b0, 2'd0);
        put(2'd1, 32'h3333_4444, 1'b1, 2'd0);
        step(); chk_word("R7", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'd1);
        step(); chk_word("R2", 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 32'h1111_2222);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            chk_word("R3", 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 32'h1111_2222);
        end
        step(); chk_word("R3", 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 32'h3333_4444);
    endtask

    // port 2 runs dry in the middle of a packet
    task automatic t_underrun();
        put(2'd2, 32'hCAFE_0001, 1'b0, 2'd0);
        step(); chk_word("R7", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'd2);
        step(); chk_word("R6", 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 32'hCAFE_0001);
        step(); chk_word("R6", 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0);
        put(2'd2, 32'hCAFE_0002, 1'b1, 2'd3);
        step(); chk_word("R6", 1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 32'hCAFE_0002);
        step(); chk_word("R5", 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0);
    endtask

    // last served is 2; ports 0,1,3 pending, expected order 3,0,1
    task automatic t_round_robin();
        put(2'd0, 32'h0000_00A0, 1'b1, 2'd1);
        put(2'd1, 32'h0000_00B1, 1'b1, 2'd1);
        put(2'd3, 32'h0000_00D3, 1'b1, 2'd1);
        step(); chk_word("R8", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'd3);
        step(); chk_word("R8", 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 32'h0000_00D3);
        step(); chk_word("R8", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'd0);
        step(); chk_word("R8", 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 32'h0000_00A0);
        step(); chk_word("R8", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'd1);
        step(); chk_word("R8", 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 32'h0000_00B1);
        step(); chk_word("R8", 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0);
    endtask

    // fill port 0, one extra write must be dropped
    task automatic t_full();
        for (int k = 0; k < DP; k++)
            put(2'd0, 32'h5000_0000 + 32'(k), (k == DP-1), 2'd0);
        check(wr_full == 4'b0001, "R11", "full flags", 64'(wr_full), 64'h1);
        put(2'd0, 32'hDEAD_BEEF, 1'b1, 2'd0);
        step(); chk_word("R11", 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'd0);
        for (int k = 0; k < DP; k++) begin
            step();
            chk_word("R11", 1'b1, 1'b0, (k == 0), (k == DP-1), 2'd0, 32'h5000_0000 + 32'(k));
        end
        step(); chk_word("R11", 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0);
        check(wr_full == 4'b0000, "R11", "full cleared", 64'(wr_full), 64'h0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_hold();
        t_underrun();
        t_round_robin();
        t_full();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule